// File: doc/BRIEF.md
# Longest-Prefix Ternary Match Engine

This block is a small ternary content-addressable table for route lookup. Each slot holds a stored value, a care mask, a live bit and a result word. The care mask has the same width as the value, and the result word has the same width as the key. A write port fills any slot at any time. A search key arrives on a valid/ready input and is compared against every slot at once. Bits whose mask bit is clear are ignored in the comparison.

Among the slots that match, the engine picks the one with the longest prefix. The prefix length is the number of ones in that slot's mask. The winner is not picked by its position in the table, so a new route can go into any free slot and the table never needs to be reordered. The result word of the winner comes out with a hit flag, a fixed number of cycles after the key was taken.

The pipeline has three register stages:
1. Each slot's key comparison is split into four equal segments, and the four segment-hit bits of every slot are registered.
2. The segment hits are ANDed into one match per slot, the longest-prefix winner is chosen, and its slot index is registered.
3. The winner's result word is read and the output is registered.

KEY_W must be a multiple of four.

Top module: `tcam_lpm_engine`

## Requirements
- R1: A key bit is compared with the stored bit only where the mask bit is 1. Where the mask bit is 0, either key value matches.
- R2: A slot whose live bit is 0 never matches. Reset clears the live bit of every slot.
- R3: When no slot matches a valid key, `res_hit` is 0 and `res_data` is all zeros. Both outputs are also 0 in every cycle where `res_valid` is 0.
- R4: When several slots match, the slot with the most mask ones wins, whatever slots the entries occupy. If two matching slots have the same length, the lower slot number wins.
- R5: A key sampled at clock edge n produces its result on the outputs right after edge n+2. At that point `res_valid` is 1 for exactly one cycle; it is never 1 earlier and never without a key.
- R6: `key_ready` is always 1. Keys presented on consecutive cycles each produce their own result, in order, on consecutive cycles.
- R7: A lookup sees the table as it stood just before the edge that sampled its key. A write sampled on that same edge, or on either of the next two edges, has no effect on that lookup's hit flag or result data. The next lookup does see the write.
- R8: Every written mask is a contiguous run of ones starting at the most significant bit. The prefix length is the count of those ones, and a mask of all zeros is a default entry of length 0.
- R9: A slot matches only if all four of its segments match. A difference confined to the least significant quarter of the key is enough to reject the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_slot | input | $clog2(ENTRIES) | Slot number to write |
| wr_value | input | KEY_W | Stored value to write |
| wr_mask | input | KEY_W | Care mask to write; 1 means the bit must match |
| wr_live | input | 1 | Live bit to write |
| wr_data | input | KEY_W | Result word to write |
| key_valid | input | 1 | A search key is present |
| key_ready | output | 1 | Always 1; a key is accepted every cycle |
| key | input | KEY_W | Search key |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | The lookup found a matching slot |
| res_data | output | KEY_W | Result word of the winning slot, zero on a miss |

## Verification
Every result is due right after the third rising edge, counting the edge that samples the key. The bench therefore samples 1 ns after that edge. It also samples 1 ns after the edge before it, to confirm that `res_valid` is still 0 there.

The streaming test presents keys back to back. It checks the result for the key taken on edge k just after edge k+2, in the same loop that drives later keys.

The write-collision test needs care, because the table holds a write for up to two edges before it fully lands. That test places one write on the key's own sampling edge and another on the following edge. It then checks that the old result comes out on the due cycle, and that the next lookup sees both writes.

// File: rtl/tcam_pkg.sv
`timescale 1ns/1ps
package tcam_pkg;
    // number of match-line segments per slot; fixed by the architecture
    localparam int unsigned SEG_COUNT = 4;
    // write commit delays that line each table part up with the stage that reads it
    localparam int unsigned LEN_COMMIT_DLY  = 1;
    localparam int unsigned DATA_COMMIT_DLY = 2;
endpackage

// File: rtl/tcam_key_table.sv
`timescale 1ns/1ps
module tcam_key_table
    import tcam_pkg::*;
#(
    parameter int unsigned KEY_W   = 32,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = $clog2(ENTRIES),
    parameter int unsigned LEN_W   = $clog2(KEY_W + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_slot,
    input  logic [KEY_W-1:0]                      wr_value,
    input  logic [KEY_W-1:0]                      wr_mask,
    input  logic                                  wr_live,
    input  logic [KEY_W-1:0]                      probe_key,
    output logic [ENTRIES-1:0][SEG_COUNT-1:0]     seg_hit,
    output logic [ENTRIES-1:0][LEN_W-1:0]         pfx_len
);
    localparam int unsigned SEG_W = KEY_W / SEG_COUNT;

    logic [KEY_W-1:0] val_q  [ENTRIES];
    logic [KEY_W-1:0] msk_q  [ENTRIES];
    logic             live_q [ENTRIES];
    logic [LEN_W-1:0] len_q  [ENTRIES];

    // prefix length lands one edge after the compare fields (stage 2 reads it)
    logic             lw_en_q;
    logic [IDX_W-1:0] lw_slot_q;
    logic [LEN_W-1:0] lw_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_en_q   <= 1'b0;
            lw_slot_q <= '0;
            lw_len_q  <= '0;
        end else begin
            lw_en_q   <= wr_en;
            lw_slot_q <= wr_slot;
            lw_len_q  <= LEN_W'($countones(wr_mask));
        end
    end

    genvar e, s;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_slot
            logic [KEY_W-1:0] diff;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_q[e] <= 1'b0;
                end else if (wr_en && wr_slot == IDX_W'(e)) begin
                    live_q[e] <= wr_live;
                    val_q[e]  <= wr_value;
                    msk_q[e]  <= wr_mask;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    len_q[e] <= '0;
                end else if (lw_en_q && lw_slot_q == IDX_W'(e)) begin
                    len_q[e] <= lw_len_q;
                end
            end

            assign diff       = (probe_key ^ val_q[e]) & msk_q[e];
            assign pfx_len[e] = len_q[e];

            for (s = 0; s < SEG_COUNT; s++) begin : g_seg
                assign seg_hit[e][s] = live_q[e] && (diff[s*SEG_W +: SEG_W] == '0);
            end
        end
    endgenerate
endmodule

// File: rtl/tcam_lpm_pick.sv
`timescale 1ns/1ps
module tcam_lpm_pick
    import tcam_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = $clog2(ENTRIES),
    parameter int unsigned LEN_W   = 6
) (
    input  logic [ENTRIES-1:0][SEG_COUNT-1:0] seg_hit,
    input  logic [ENTRIES-1:0][LEN_W-1:0]     pfx_len,
    output logic                              any_hit,
    output logic [IDX_W-1:0]                  win_idx
);
    logic [ENTRIES-1:0] slot_hit;
    logic [LEN_W-1:0]   best_len;

    genvar e;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_and
            assign slot_hit[e] = &seg_hit[e];
        end
    endgenerate

    // strict comparison keeps the lower slot on equal lengths
    always_comb begin
        any_hit  = 1'b0;
        best_len = '0;
        win_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (slot_hit[i] && (!any_hit || pfx_len[i] > best_len)) begin
                any_hit  = 1'b1;
                best_len = pfx_len[i];
                win_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_result_store.sv
`timescale 1ns/1ps
module tcam_result_store
    import tcam_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [ENTRIES];

    logic              d_en   [DATA_COMMIT_DLY];
    logic [IDX_W-1:0]  d_slot [DATA_COMMIT_DLY];
    logic [DATA_W-1:0] d_data [DATA_COMMIT_DLY];

    genvar k;
    generate
        for (k = 0; k < DATA_COMMIT_DLY; k++) begin : g_dly
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_en[k]   <= 1'b0;
                    d_slot[k] <= '0;
                    d_data[k] <= '0;
                end else if (k == 0) begin
                    d_en[k]   <= wr_en;
                    d_slot[k] <= wr_slot;
                    d_data[k] <= wr_data;
                end else begin
                    d_en[k]   <= d_en[k-1];
                    d_slot[k] <= d_slot[k-1];
                    d_data[k] <= d_data[k-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (d_en[DATA_COMMIT_DLY-1]) begin
            mem[d_slot[DATA_COMMIT_DLY-1]] <= d_data[DATA_COMMIT_DLY-1];
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/tcam_lpm_engine.sv
`timescale 1ns/1ps
module tcam_lpm_engine
    import tcam_pkg::*;
#(
    parameter int unsigned KEY_W   = 32,
    parameter int unsigned ENTRIES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(ENTRIES)-1:0]  wr_slot,
    input  logic [KEY_W-1:0]            wr_value,
    input  logic [KEY_W-1:0]            wr_mask,
    input  logic                        wr_live,
    input  logic [KEY_W-1:0]            wr_data,
    input  logic                        key_valid,
    output logic                        key_ready,
    input  logic [KEY_W-1:0]            key,
    output logic                        res_valid,
    output logic                        res_hit,
    output logic [KEY_W-1:0]            res_data
);
    localparam int unsigned DATA_W = KEY_W;
    localparam int unsigned IDX_W  = $clog2(ENTRIES);
    localparam int unsigned LEN_W  = $clog2(KEY_W + 1);

    logic [ENTRIES-1:0][SEG_COUNT-1:0] seg_hit;
    logic [ENTRIES-1:0][LEN_W-1:0]     pfx_len;
    logic [ENTRIES-1:0][SEG_COUNT-1:0] s1_seg;
    logic                              s1_vld;
    logic                              pick_any;
    logic [IDX_W-1:0]                  pick_idx;
    logic                              s2_vld;
    logic                              s2_hit;
    logic [IDX_W-1:0]                  s2_idx;
    logic [DATA_W-1:0]                 rd_data;

    assign key_ready = 1'b1;

    tcam_key_table #(
        .KEY_W(KEY_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_value(wr_value),
        .wr_mask(wr_mask), .wr_live(wr_live),
        .probe_key(key), .seg_hit(seg_hit), .pfx_len(pfx_len)
    );

    // stage 1: segment compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_seg <= '0;
        end else begin
            s1_vld <= key_valid;
            s1_seg <= seg_hit;
        end
    end

    tcam_lpm_pick #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_pick (
        .seg_hit(s1_seg), .pfx_len(pfx_len),
        .any_hit(pick_any), .win_idx(pick_idx)
    );

    // stage 2: combine segments, select longest prefix
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_hit <= 1'b0;
            s2_idx <= '0;
        end else begin
            s2_vld <= s1_vld;
            s2_hit <= s1_vld && pick_any;
            s2_idx <= pick_idx;
        end
    end

    tcam_result_store #(
        .DATA_W(DATA_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
        .rd_idx(s2_idx), .rd_data(rd_data)
    );

    // stage 3: result read and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= s2_vld;
            res_hit   <= s2_vld && s2_hit;
            res_data  <= (s2_vld && s2_hit) ? rd_data : '0;
        end
    end
endmodule

// File: rtl/tcam_lpm_checks.sv
`timescale 1ns/1ps
module tcam_lpm_checks #(
    parameter int unsigned KEY_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [KEY_W-1:0] wr_mask,
    input logic             key_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [KEY_W-1:0] res_data
);
    logic [KEY_W-1:0] inv_mask;
    assign inv_mask = ~wr_mask;

    // R5
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(key_valid, 3));

    // R5
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_data == '0));

    // R8
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((inv_mask & (inv_mask + KEY_W'(1))) == '0));
endmodule

bind tcam_lpm_engine tcam_lpm_checks #(.KEY_W(KEY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
    .key_valid(key_valid), .res_valid(res_valid), .res_hit(res_hit),
    .res_data(res_data)
);

// File: tb/sim_tcam_lpm_engine.sv
`timescale 1ns/1ps
module sim_tcam_lpm_engine;
    localparam int KW = 32;
    localparam int NE = 8;
    localparam int IW = $clog2(NE);
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_slot = '0;
    logic [KW-1:0] wr_value = '0;
    logic [KW-1:0] wr_mask = '0;
    logic          wr_live = 1'b0;
    logic [KW-1:0] wr_data = '0;
    logic          key_valid = 1'b0;
    logic          key_ready;
    logic [KW-1:0] key = '0;
    logic          res_valid;
    logic          res_hit;
    logic [KW-1:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [KW-1:0] m_val [NE];
    logic [KW-1:0] m_msk [NE];
    logic [KW-1:0] m_dat [NE];
    bit            m_live[NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    tcam_lpm_engine #(.KEY_W(KW), .ENTRIES(NE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_value(wr_value),
        .wr_mask(wr_mask), .wr_live(wr_live), .wr_data(wr_data),
        .key_valid(key_valid), .key_ready(key_ready), .key(key),
        .res_valid(res_valid), .res_hit(res_hit), .res_data(res_data)
    );

    function automatic logic [KW-1:0] len_mask(input int len);
        return {KW{1'b1}} << (KW - len);
    endfunction

    function automatic int ones(input logic [KW-1:0] m);
        int c = 0;
        for (int i = 0; i < KW; i++) c += int'(m[i]);
        return c;
    endfunction

    // reference: longest mask wins, lower slot on ties, misses give zero
    task automatic model(input logic [KW-1:0] k, output bit hit, output logic [KW-1:0] d);
        int best = -1;
        hit = 1'b0;
        d   = '0;
        for (int i = 0; i < NE; i++) begin
            if (m_live[i] && (((k ^ m_val[i]) & m_msk[i]) == '0) && ones(m_msk[i]) > best) begin
                best = ones(m_msk[i]);
                hit  = 1'b1;
                d    = m_dat[i];
            end
        end
    endtask

    task automatic check(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int slot, input logic [KW-1:0] v, input int len,
                            input bit live, input logic [KW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = IW'(slot); wr_value = v;
        wr_mask = len_mask(len); wr_live = live; wr_data = d;
        @(posedge clk);
        m_val[slot] = v; m_msk[slot] = len_mask(len); m_live[slot] = live; m_dat[slot] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_lookup(input string req, input logic [KW-1:0] k);
        bit eh;
        logic [KW-1:0] ed;
        model(k, eh, ed);
        @(negedge clk);
        key = k; key_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        key_valid = 1'b0;
        @(posedge clk);
        #1;
        check({req, " R5 not early"}, KW'(res_valid), '0);
        @(posedge clk);
        #1;
        check({req, " R5 valid"}, KW'(res_valid), KW'(1));
        check({req, " hit"}, KW'(res_hit), KW'(eh));
        check({req, " data"}, res_data, ed);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NE; i++) begin
            m_live[i] = 1'b0; m_val[i] = '0; m_msk[i] = '0; m_dat[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset res_valid", KW'(res_valid), '0);
        check("R3 reset res_hit", KW'(res_hit), '0);
        check("R3 reset res_data", res_data, '0);
        check("R6 key_ready", KW'(key_ready), KW'(1));
        @(negedge clk);
        rst_n = 1'b1;
        do_lookup("R2 empty table miss", 32'h0A010203);
    endtask

    task automatic t_basic();
        do_write(3, 32'h0A000000, 8, 1'b1, 32'hAAAA0001);
        do_lookup("R1 masked bits ignored", 32'h0A010203);
        do_lookup("R3 miss zero", 32'h0B010203);
    endtask

    task automatic t_lpm();
        do_write(0, 32'h0A010000, 16, 1'b1, 32'hBBBB0002);
        do_write(7, 32'h0A010200, 24, 1'b1, 32'hCCCC0003);
        do_write(2, 32'h00000000, 0, 1'b1, 32'hDDDD0004);
        do_lookup("R4 /24 in high slot", 32'h0A010203);
        do_lookup("R4 /16 in slot 0", 32'h0A010909);
        do_lookup("R4 /8 over default", 32'h0A090909);
        do_lookup("R8 zero mask default", 32'h63000000);
    endtask

    task automatic t_segments();
        do_write(4, 32'h0A010204, 32, 1'b1, 32'hEEEE0005);
        do_lookup("R9 exact all segments", 32'h0A010204);
        do_lookup("R9 low segment differs", 32'h0A010205);
    endtask

    task automatic t_invalidate();
        do_write(7, 32'h0A010200, 24, 1'b0, 32'hCCCC0003);
        do_lookup("R2 cleared live bit", 32'h0A010203);
    endtask

    task automatic t_tie();
        do_write(6, 32'h0C000000, 8, 1'b1, 32'h66660006);
        do_write(1, 32'h0C000000, 8, 1'b1, 32'h11110001);
        do_lookup("R4 equal length lower slot", 32'h0C345678);
    endtask

    task automatic t_stream();
        logic [KW-1:0] ks [6];
        bit            eh [6];
        logic [KW-1:0] ed [6];
        ks[0] = 32'h0A010203; ks[1] = 32'h0C000001; ks[2] = 32'h0A010204;
        ks[3] = 32'h77777777; ks[4] = 32'h0A0A0A0A; ks[5] = 32'h0A01FFFF;
        for (int i = 0; i < 6; i++) model(ks[i], eh[i], ed[i]);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i < 6) begin
                key = ks[i]; key_valid = 1'b1;
            end else begin
                key_valid = 1'b0;
            end
            @(posedge clk);
            #1;
            if (i >= 2) begin
                check("R6 stream valid", KW'(res_valid), KW'(1));
                check("R6 stream hit", KW'(res_hit), KW'(eh[i-2]));
                check("R6 stream data", res_data, ed[i-2]);
            end
        end
        @(negedge clk);
        @(posedge clk);
        #1;
        check("R6 stream ends", KW'(res_valid), '0);
    endtask

    task automatic t_collide();
        bit            eh;
        logic [KW-1:0] ed;
        model(32'h0A010203, eh, ed);
        @(negedge clk);
        key = 32'h0A010203; key_valid = 1'b1;
        wr_en = 1'b1; wr_slot = IW'(5); wr_value = 32'h0A010200;
        wr_mask = len_mask(28); wr_live = 1'b1; wr_data = 32'hFFFF0007;
        @(posedge clk);
        @(negedge clk);
        key_valid = 1'b0;
        wr_slot = IW'(0); wr_value = 32'h0A010000; wr_mask = len_mask(16);
        wr_live = 1'b1; wr_data = 32'h99990008;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R7 in-flight valid", KW'(res_valid), KW'(1));
        check("R7 in-flight hit", KW'(res_hit), KW'(eh));
        check("R7 in-flight old data", res_data, ed);
        m_val[5] = 32'h0A010200; m_msk[5] = len_mask(28); m_live[5] = 1'b1; m_dat[5] = 32'hFFFF0007;
        m_dat[0] = 32'h99990008;
        do_lookup("R7 next sees new /28", 32'h0A010203);
        do_lookup("R7 next sees new data", 32'h0A010909);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_lpm();
        t_segments();
        t_invalidate();
        t_tie();
        t_stream();
        t_collide();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule